// File: doc/BRIEF.md
# Write-Permission and Block-Protect Gate

This block decides, one bus byte at a time, whether a serial write to a small register space or to a 2K-byte nonvolatile array may go ahead. A bus front end, which handles pin timing, turns the wire activity into byte-level events: start, stop, a complete received byte, and a stop that arrives in the middle of a byte. For every complete byte the gate returns an acknowledge decision. It also streams accepted data bytes, with their page-wrapped addresses, to a downstream staging buffer, and asks for a commit when a valid write ends.

Register writes are unlocked in two steps through a volatile status location: first write enable, then register write enable. A write to a protected part of the array is acknowledged but silently dropped. A three-bit protect field selects the protected region. After a commit the block reports busy for a parameterised number of clocks, which stands for the nonvolatile programming time. While busy it acknowledges nothing. At the end of that time the register write enable clears itself.

There is no back-pressure on either stream. Bus events arrive in real time and are always consumed, one per `ev_valid` cycle. The write-byte stream (`wr_valid`) has no ready signal, so the staging buffer must accept one byte in any cycle.

Top module: `wrgate_top`

## Requirements
- R1: A byte in the slave-byte position is acknowledged only when its upper seven bits are 1010111 (array space) or 1101111 (register space). Bit 0 set means read: the byte is acknowledged and later bytes are left to other logic. Any other slave value is not acknowledged, and every byte until the next start is not acknowledged. Event codes on `ev_kind` are: 0 start, 1 stop, 2 byte complete, 3 stop inside a byte.
- R2: A register-space write whose address low byte is 3Fh targets the status location. Its single data byte is acknowledged and takes effect at the stop. 00h clears both enables. 02h sets write enable and clears register write enable. 06h sets both, but only when write enable is already set; otherwise nothing changes. Any other value changes nothing. A status write never raises `commit` or `busy`.
- R3: A second data byte in a status write is not acknowledged, and the whole status write is discarded.
- R4: An array data byte is acknowledged only when write enable is set. Otherwise it is not acknowledged, nothing is streamed, and no commit follows.
- R5: A register data byte (start address other than 3Fh) is acknowledged only when both enables are set.
- R6: Protect field decode (array address): 000 none; 001 600h-7FFh; 010 400h-7FFh; 011 all; 100 000h-03Fh; 101 000h-07Fh; 110 000h-0FFh; 111 000h-1FFh. A protected byte is acknowledged but not streamed. A stop raises `commit` only if at least one byte was streamed.
- R7: The write address advances by one after each data byte. It wraps within a 64-byte page for the array and within an 8-byte section for registers, so extra bytes overwrite earlier addresses.
- R8: A stop before any data byte, a stop inside a byte, or a repeated start ends the transaction with no commit and no change to the enables.
- R9: A valid stop gives a one-cycle `commit` pulse, together with `commit_space`. `busy` is high for exactly BUSY_CYCLES cycles, starting in the commit cycle.
- R10: While `busy` is high, every byte is not acknowledged and nothing is streamed.
- R11: Register write enable clears in the cycle `busy` falls. Write enable is kept.
- R12: Every byte event gives `ack_valid` one cycle later. `stg_clear` pulses with the acknowledge of the address low byte of a non-status write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | A bus event is present this cycle |
| ev_kind | input | 2 | Event code (0 start, 1 stop, 2 byte, 3 stop in byte) |
| ev_byte | input | 8 | Received byte for a byte event |
| bp | input | 3 | Array protect field |
| ack_valid | output | 1 | An acknowledge decision is present |
| ack | output | 1 | 1 = acknowledge the byte |
| wr_valid | output | 1 | A data byte is streamed to staging |
| wr_space | output | 1 | 0 array, 1 register space |
| wr_addr | output | ARR_AW | Address of the streamed byte |
| wr_data | output | 8 | Streamed byte |
| stg_clear | output | 1 | Staging buffer should drop old content |
| commit | output | 1 | Program the staged bytes |
| commit_space | output | 1 | Space of the commit |
| busy | output | 1 | Programming in progress |
| wel | output | 1 | Write enable state |
| rwel | output | 1 | Register write enable state |

## Verification
Every result caused by a byte event (`ack_valid`, `ack`, `wr_valid`, address, data, `stg_clear`) is registered once. It is due one cycle after the edge that takes the event. Results of a stop (`commit`, `busy`, new enable states) are due in the same following cycle. The bench drives each event on a falling edge and holds it for one cycle. It samples at the next falling edge, which is exactly one rising edge later. For the busy window, it samples again BUSY_CYCLES-1 cycles later (still busy) and BUSY_CYCLES cycles later (idle, with register write enable cleared).

// File: rtl/wrgate_pkg.sv
package wrgate_pkg;
  typedef enum logic [1:0] {
    EV_START = 2'd0,
    EV_STOP  = 2'd1,
    EV_BYTE  = 2'd2,
    EV_ABORT = 2'd3
  } ev_kind_e;

  typedef enum logic [2:0] {
    S_IDLE, S_SLV, S_ADR1, S_ADR0, S_DATA, S_IGN
  } fsm_e;

  localparam logic [6:0] ID_ARRAY = 7'b1010111;
  localparam logic [6:0] ID_REGS  = 7'b1101111;
endpackage

// File: rtl/wrgate_prot.sv
module wrgate_prot #(
  parameter int ARR_AW  = 11,
  parameter int PAGE_AW = 6
) (
  input  logic [2:0]        bp,
  input  logic [ARR_AW-1:0] addr,
  output logic              prot
);
  logic [ARR_AW:0] low_lim;

  always_comb begin
    low_lim = (ARR_AW+1)'(1) << (PAGE_AW + int'(bp[1:0]));
    case (bp)
      3'b000:  prot = 1'b0;
      3'b001:  prot = addr[ARR_AW-1] & addr[ARR_AW-2];
      3'b010:  prot = addr[ARR_AW-1];
      3'b011:  prot = 1'b1;
      default: prot = ({1'b0, addr} < low_lim);
    endcase
  end

  // R6: the first page is covered by every low-range setting
  always_comb begin
    p_first_page_r6: assert (!(bp[2] && addr[ARR_AW-1:PAGE_AW] == '0) || prot);
    p_none_r6: assert (bp != 3'b000 || !prot);
  end
endmodule

// File: rtl/wrgate_latch.sv
module wrgate_latch (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       st_wr,
  input  logic [7:0] st_val,
  input  logic       nv_done,
  output logic       wel,
  output logic       rwel
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wel  <= 1'b0;
      rwel <= 1'b0;
    end else if (st_wr) begin
      case (st_val)
        8'h00: begin wel <= 1'b0; rwel <= 1'b0; end
        8'h02: begin wel <= 1'b1; rwel <= 1'b0; end
        8'h06: if (wel) begin wel <= 1'b1; rwel <= 1'b1; end
        default: ;
      endcase
    end else if (nv_done) begin
      rwel <= 1'b0;
    end
  end

  p_rwel_needs_wel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rwel |-> wel);
  p_rwel_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    nv_done |=> !rwel);
  p_done_keeps_wel_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_done && !st_wr) |=> (wel == $past(wel)));
endmodule

// File: rtl/wrgate_timer.sv
module wrgate_timer #(
  parameter int BUSY_CYCLES = 1250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(BUSY_CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (start)  cnt <= LOAD;
    else if (busy)   cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
  assign done = (cnt == CW'(1));

  p_start_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
  p_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
endmodule

// File: rtl/wrgate_top.sv
module wrgate_top
  import wrgate_pkg::*;
#(
  parameter int ARR_AW      = 11,
  parameter int PAGE_AW     = 6,
  parameter int SEC_AW      = 3,
  parameter int REG_AW      = 6,
  parameter int STAT_ADDR   = 63,
  parameter int BUSY_CYCLES = 1250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic [1:0]        ev_kind,
  input  logic [7:0]        ev_byte,
  input  logic [2:0]        bp,
  output logic              ack_valid,
  output logic              ack,
  output logic              wr_valid,
  output logic              wr_space,
  output logic [ARR_AW-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              stg_clear,
  output logic              commit,
  output logic              commit_space,
  output logic              busy,
  output logic              wel,
  output logic              rwel
);
  localparam logic [REG_AW-1:0] STAT_A = REG_AW'(STAT_ADDR);

  fsm_e              st, st_n;
  logic [7:0]        hi, hi_n, sv, sv_n;
  logic [ARR_AW-1:0] ptr, ptr_n, ptr_inc;
  logic              spc, spc_n, stat, stat_n, nb, nb_n, emit, emit_n;
  logic              ackv_n, ack_n, wrv_n, clr_n, com_n, st_wr;
  logic [ARR_AW-1:0] wra_n;
  logic [7:0]        wrd_n;
  logic [15:0]       a16;
  logic              prot, nv_done, allowed;

  wrgate_prot #(.ARR_AW(ARR_AW), .PAGE_AW(PAGE_AW)) u_prot (
    .bp(bp), .addr(ptr), .prot(prot));

  wrgate_latch u_latch (
    .clk(clk), .rst_n(rst_n), .st_wr(st_wr), .st_val(sv),
    .nv_done(nv_done), .wel(wel), .rwel(rwel));

  wrgate_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(com_n), .busy(busy), .done(nv_done));

  // page or section wrap of the running pointer
  generate
    if (ARR_AW > PAGE_AW) begin : g_wrap
      always_comb begin
        if (spc)
          ptr_inc = {ptr[ARR_AW-1:SEC_AW], ptr[SEC_AW-1:0] + 1'b1};
        else
          ptr_inc = {ptr[ARR_AW-1:PAGE_AW], ptr[PAGE_AW-1:0] + 1'b1};
      end
    end else begin : g_flat
      assign ptr_inc = ptr + 1'b1;
    end
  endgenerate

  assign a16     = {hi, ev_byte};
  assign allowed = wel && (!spc || rwel);

  always_comb begin
    st_n = st; hi_n = hi; sv_n = sv; ptr_n = ptr;
    spc_n = spc; stat_n = stat; nb_n = nb; emit_n = emit;
    ackv_n = 1'b0; ack_n = 1'b0; wrv_n = 1'b0; clr_n = 1'b0;
    com_n = 1'b0; st_wr = 1'b0;
    wra_n = wr_addr; wrd_n = wr_data;
    if (ev_valid) begin
      case (ev_kind)
        EV_START: st_n = S_SLV;
        EV_ABORT: st_n = S_IDLE;
        EV_STOP: begin
          if (st == S_DATA && nb) begin
            if (stat)      st_wr = 1'b1;
            else if (emit) com_n = 1'b1;
          end
          st_n = S_IDLE;
        end
        default: begin
          ackv_n = 1'b1;
          if (busy) begin
            if (st != S_IDLE) st_n = S_IGN;
          end else begin
            case (st)
              S_SLV: begin
                if (ev_byte[7:1] == ID_ARRAY || ev_byte[7:1] == ID_REGS) begin
                  ack_n = 1'b1;
                  spc_n = (ev_byte[7:1] == ID_REGS);
                  st_n  = ev_byte[0] ? S_IGN : S_ADR1;
                end else begin
                  st_n = S_IGN;
                end
              end
              S_ADR1: begin
                ack_n = 1'b1;
                hi_n  = ev_byte;
                st_n  = S_ADR0;
              end
              S_ADR0: begin
                ack_n  = 1'b1;
                ptr_n  = a16[ARR_AW-1:0];
                stat_n = spc && (a16[REG_AW-1:0] == STAT_A);
                clr_n  = !stat_n;
                nb_n   = 1'b0;
                emit_n = 1'b0;
                st_n   = S_DATA;
              end
              S_DATA: begin
                if (stat) begin
                  if (!nb) begin
                    ack_n = 1'b1;
                    sv_n  = ev_byte;
                    nb_n  = 1'b1;
                  end else begin
                    st_n = S_IGN;
                  end
                end else if (allowed) begin
                  ack_n = 1'b1;
                  nb_n  = 1'b1;
                  ptr_n = ptr_inc;
                  if (spc || !prot) begin
                    wrv_n  = 1'b1;
                    wra_n  = ptr;
                    wrd_n  = ev_byte;
                    emit_n = 1'b1;
                  end
                end else begin
                  st_n = S_IGN;
                end
              end
              default: ;
            endcase
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; hi <= '0; sv <= '0; ptr <= '0;
      spc <= 1'b0; stat <= 1'b0; nb <= 1'b0; emit <= 1'b0;
      ack_valid <= 1'b0; ack <= 1'b0; wr_valid <= 1'b0; wr_space <= 1'b0;
      wr_addr <= '0; wr_data <= '0; stg_clear <= 1'b0;
      commit <= 1'b0; commit_space <= 1'b0;
    end else begin
      st <= st_n; hi <= hi_n; sv <= sv_n; ptr <= ptr_n;
      spc <= spc_n; stat <= stat_n; nb <= nb_n; emit <= emit_n;
      ack_valid <= ackv_n; ack <= ack_n; wr_valid <= wrv_n;
      wr_addr <= wra_n; wr_data <= wrd_n; stg_clear <= clr_n;
      if (wrv_n) wr_space <= spc;
      commit <= com_n;
      if (com_n) commit_space <= spc;
    end
  end

  p_wr_needs_wel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wel);
  p_reg_needs_rwel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_space) |-> rwel);
  p_busy_nack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack) |-> !$past(busy));
  p_commit_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> busy);
  p_commit_fresh_r9: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !$past(busy));
  p_ack_has_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ack || wr_valid || stg_clear) |-> ack_valid);
endmodule

// File: tb/sim_wrgate_top.sv
module sim_wrgate_top;
  localparam int BUSY = 20;
  localparam logic [1:0] K_START = 2'd0, K_STOP = 2'd1, K_BYTE = 2'd2, K_ABORT = 2'd3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_valid = 1'b0;
  logic [1:0] ev_kind = 2'd0;
  logic [7:0] ev_byte = 8'd0;
  logic [2:0] bp = 3'd0;
  logic ack_valid, ack, wr_valid, wr_space, stg_clear, commit, commit_space, busy, wel, rwel;
  logic [10:0] wr_addr;
  logic [7:0] wr_data;

  int total = 0, bad = 0;
  bit m_wel = 0, m_rwel = 0, done_flag = 0;

  always #4 clk = ~clk;

  wrgate_top #(.BUSY_CYCLES(BUSY)) u0 (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind),
    .ev_byte(ev_byte), .bp(bp), .ack_valid(ack_valid), .ack(ack),
    .wr_valid(wr_valid), .wr_space(wr_space), .wr_addr(wr_addr),
    .wr_data(wr_data), .stg_clear(stg_clear), .commit(commit),
    .commit_space(commit_space), .busy(busy), .wel(wel), .rwel(rwel));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit f_prot(input logic [2:0] b, input int a);
    case (b)
      3'd0: return 0;
      3'd1: return a >= 'h600;
      3'd2: return a >= 'h400;
      3'd3: return 1;
      3'd4: return a < 'h40;
      3'd5: return a < 'h80;
      3'd6: return a < 'h100;
      default: return a < 'h200;
    endcase
  endfunction

  function automatic int f_next(input bit sp, input int a);
    if (sp) return (a & ~7) | ((a + 1) & 7);
    return (a & ~63) | ((a + 1) & 63);
  endfunction

  task automatic ev(input logic [1:0] k, input logic [7:0] b);
    @(negedge clk);
    ev_valid = 1'b1; ev_kind = k; ev_byte = b;
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic sw(input logic [7:0] v);
    ev(K_START, 0);
    ev(K_BYTE, 8'hDE);
    ev(K_BYTE, 8'h00);
    ev(K_BYTE, 8'h3F);
    chk(stg_clear == 0, "R12 status no clear", stg_clear, 0);
    ev(K_BYTE, v);
    chk(ack_valid && ack, "R2 status ack", ack, 1);
    ev(K_STOP, 0);
    chk(!commit && !busy, "R2 no commit", commit, 0);
    case (v)
      8'h00: begin m_wel = 0; m_rwel = 0; end
      8'h02: begin m_wel = 1; m_rwel = 0; end
      8'h06: if (m_wel) m_rwel = 1;
      default: ;
    endcase
    chk(wel == m_wel, "R2 wel", wel, m_wel);
    chk(rwel == m_rwel, "R2 rwel", rwel, m_rwel);
  endtask

  task automatic wr_txn(input bit sp, input int a0, input int n, input logic [7:0] d0);
    int a;
    bit any, ok, exp_e;
    a = a0; any = 0;
    ev(K_START, 0);
    ev(K_BYTE, sp ? 8'hDE : 8'hAE);
    chk(ack_valid && ack, "R1 slave ack", ack, 1);
    ev(K_BYTE, 8'((a0 >> 8) & 'hFF));
    chk(ack_valid && ack, "R12 addr hi ack", ack, 1);
    ev(K_BYTE, 8'(a0 & 'hFF));
    chk(stg_clear == 1, "R12 stage clear", stg_clear, 1);
    ok = sp ? (m_wel && m_rwel) : m_wel;
    for (int i = 0; i < n; i++) begin
      ev(K_BYTE, d0 + 8'(i));
      chk(ack_valid && ack == ok, sp ? "R5 data ack" : "R4 data ack", ack, ok);
      if (!ok) break;
      exp_e = sp || !f_prot(bp, a);
      chk(wr_valid == exp_e, "R6 stream", wr_valid, exp_e);
      if (exp_e) begin
        chk(wr_addr == 11'(a), "R7 address", wr_addr, a);
        chk(wr_data == d0 + 8'(i), "R7 data", wr_data, d0 + 8'(i));
        any = 1;
      end
      a = f_next(sp, a);
    end
    ev(K_STOP, 0);
    chk(commit == any, "R9 commit", commit, any);
    if (any) begin
      chk(busy == 1 && commit_space == sp, "R9 busy start", busy, 1);
      repeat (BUSY - 1) @(negedge clk);
      chk(busy == 1, "R9 busy held", busy, 1);
      @(negedge clk);
      chk(busy == 0, "R9 busy end", busy, 0);
      m_rwel = 0;
      chk(rwel == 0, "R11 rwel cleared", rwel, 0);
      chk(wel == m_wel, "R11 wel kept", wel, m_wel);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4321));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!ack_valid && !busy && !commit, "R12 reset outputs", busy, 0);
    chk(!wel && !rwel, "R2 reset enables", wel, 0);

    // R1: foreign slave byte
    ev(K_START, 0);
    ev(K_BYTE, 8'hA0);
    chk(ack_valid && !ack, "R1 bad id nack", ack, 0);
    ev(K_BYTE, 8'h00);
    chk(ack_valid && !ack, "R1 ignored after", ack, 0);
    ev(K_STOP, 0);

    // R4: array write without enable
    wr_txn(0, 'h010, 2, 8'h11);

    // R2: unlock sequence rules
    sw(8'h06);
    sw(8'h02);
    sw(8'h55);
    sw(8'h06);
    sw(8'h00);
    sw(8'h02);

    // R3: two status bytes
    ev(K_START, 0); ev(K_BYTE, 8'hDE); ev(K_BYTE, 8'h00); ev(K_BYTE, 8'h3F);
    ev(K_BYTE, 8'h06);
    chk(ack == 1, "R3 first ack", ack, 1);
    ev(K_BYTE, 8'h06);
    chk(ack_valid && !ack, "R3 second nack", ack, 0);
    ev(K_STOP, 0);
    chk(rwel == 0 && wel == 1, "R3 discarded", rwel, 0);

    // R5: register write needs both
    wr_txn(1, 'h08, 1, 8'h21);
    sw(8'h06);
    wr_txn(1, 'h06, 3, 8'h30);   // R7 section wrap 06,07,00

    // R7: page wrap in array
    bp = 3'd0;
    wr_txn(0, 'h13E, 4, 8'h40);

    // R6: protect cases
    bp = 3'd4; wr_txn(0, 'h03E, 2, 8'h50);
    bp = 3'd1; wr_txn(0, 'h7FF, 2, 8'h60);
    bp = 3'd1; wr_txn(0, 'h5FE, 3, 8'h70);
    bp = 3'd7; wr_txn(0, 'h200, 1, 8'h80);
    bp = 3'd3; wr_txn(0, 'h000, 1, 8'h90);

    // R8: abandoned transactions
    bp = 3'd0;
    sw(8'h06);
    ev(K_START, 0); ev(K_BYTE, 8'hAE); ev(K_BYTE, 8'h00); ev(K_BYTE, 8'h20);
    ev(K_STOP, 0);
    chk(!commit && !busy, "R8 stop before data", commit, 0);
    ev(K_START, 0); ev(K_BYTE, 8'hAE); ev(K_BYTE, 8'h00); ev(K_BYTE, 8'h20);
    ev(K_BYTE, 8'h01); ev(K_ABORT, 0);
    chk(!commit && !busy, "R8 abort", commit, 0);
    ev(K_START, 0); ev(K_BYTE, 8'hDE); ev(K_BYTE, 8'h00); ev(K_BYTE, 8'h01);
    ev(K_BYTE, 8'h01); ev(K_START, 0); ev(K_STOP, 0);
    chk(!commit && rwel == 1 && wel == 1, "R8 restart keeps enables", rwel, 1);

    // R10: nothing acknowledged while busy
    ev(K_START, 0); ev(K_BYTE, 8'hAE); ev(K_BYTE, 8'h00); ev(K_BYTE, 8'h30);
    ev(K_BYTE, 8'h5A); ev(K_STOP, 0);
    chk(commit == 1, "R10 setup commit", commit, 1);
    ev(K_START, 0); ev(K_BYTE, 8'hAE);
    chk(ack_valid && !ack && busy, "R10 busy nack", ack, 0);
    ev(K_STOP, 0);
    repeat (BUSY) @(negedge clk);
    m_rwel = 0;
    chk(!busy && !rwel, "R11 after busy", rwel, 0);

    // random mix
    for (int t = 0; t < 30; t++) begin
      bit sp;
      sp = ($urandom % 4) == 0;
      bp = 3'($urandom % 8);
      if (sp) begin
        if (!m_rwel) sw(8'h06);
        wr_txn(1, int'($urandom % 'h38), 1 + int'($urandom % 12), 8'($urandom));
      end else begin
        wr_txn(0, int'($urandom % 'h800), 1 + int'($urandom % 70), 8'($urandom));
      end
    end

    done_flag = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule